// File: doc/BRIEF.md
# PI-Steered Local Time Counter

This block holds a local time of day as a seconds count and a nanoseconds count and advances it by a fixed nominal step on every system clock cycle. It is steered towards occasional reference time snapshots by a proportional-integral loop. The loop's correction is expressed in femtoseconds per cycle. It is summed into a signed femtosecond remainder, and the nanosecond count moves by one extra nanosecond only when that remainder crosses plus or minus one nanosecond.

The loop runs only when a reference value arrives that differs from the last one accepted. The first accepted reference after reset, and any reference further than the slew limit from the local time, is loaded directly. All nearer references are slewed in through the proportional and integral terms. The proportional gain comes from an input port. It is scaled so that a gain of about ten spreads an error over roughly ten milliseconds at the default 40 MHz clock.

Top module: `pi_time_keeper`

## Requirements
- R1: While reset is asserted, the seconds, nanoseconds and femtosecond outputs are all zero, and the correction terms are zero.
- R2: With zero correction, the nanoseconds output grows by exactly 25 on each cycle. It stays below 1,000,000,000; on reaching that value it wraps, and the seconds output grows by one in the same cycle.
- R3: On each cycle the current correction is added to the femtosecond remainder. A sum of +1,000,000 or more is reduced by 1,000,000 and the nanosecond step that cycle is 26. A sum of -1,000,000 or less is raised by 1,000,000 and the step is 24. The remainder stays strictly between -1,000,000 and +1,000,000.
- R4: The first reference accepted after reset loads the time. In the next cycle the outputs equal the reference seconds and nanoseconds exactly, with no step added, and the remainder is zero. Both correction terms are cleared.
- R5: A reference is accepted only in a cycle where its valid strobe is high and its value differs from the last accepted value. A value that is held or repeated leaves the time advancing as if no reference were present.
- R6: The error is the reference minus the local time of the acceptance cycle, in nanoseconds. If its magnitude exceeds 1000 ns, or the seconds differ by more than one, the time is reloaded exactly as in R4.
- R7: On a slew (|error| <= 1000 ns), the proportional term becomes floor(gain * error / 4) fs per cycle, clipped to +/-131071. It takes effect from the next cycle.
- R8: On a slew the integral term steps by +1 fs for a positive error and by -1 fs for a negative one, and stays unchanged for a zero error. It is clipped to +/-131071.
- R9: The per-cycle correction is the sum of the proportional and integral terms, clipped to +/-131071 fs. The cycle in which a slew is accepted still uses the previous correction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (nominal 40 MHz) |
| rst_n | input | 1 | Asynchronous active-low reset |
| refValid | input | 1 | Reference snapshot present this cycle |
| refSec | input | 32 | Reference seconds |
| refNs | input | 30 | Reference nanoseconds (below 1e9) |
| kpGain | input | 12 | Proportional gain, units of 1/4 fs per cycle per ns |
| timeSec | output | 32 | Local time, seconds |
| timeNs | output | 30 | Local time, nanoseconds |
| timeFs | output | 21 | Signed femtosecond remainder |

## Verification
The two functions that can fall in the same cycle are a femtosecond carry (or borrow) and the wrap of nanoseconds into seconds. A slew can also be accepted in that same cycle. The bench provokes this overlap by loading times just short of a second boundary at eight staggered offsets. Each load is followed by a saturated slew whose target lies in the next second, so the error is formed across the boundary and one of the carries lands on the wrap cycle. A behavioural model that works from total nanoseconds is compared with the outputs on every cycle, so a step of 26 that also wraps is judged on both counters at once.

// File: rtl/pi_time_pkg.sv
package pi_time_pkg;
  typedef struct packed {
    logic load;   // take the reference verbatim
    logic slew;   // update proportional and integral terms
  } tk_strobe_t;
endpackage

// File: rtl/pi_time_ctl.sv
module pi_time_ctl
  import pi_time_pkg::*;
#(
  parameter int SEC_W = 32,
  parameter int NS_W  = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             refValid,
  input  logic [SEC_W-1:0] refSec,
  input  logic [NS_W-1:0]  refNs,
  input  logic             overLimit,
  output tk_strobe_t       stb
);
  logic             haveRef;
  logic [SEC_W-1:0] lastSec;
  logic [NS_W-1:0]  lastNs;
  logic             fresh;

  always_comb begin
    fresh    = refValid && (!haveRef || refSec != lastSec || refNs != lastNs);
    stb.load = fresh && (!haveRef || overLimit);
    stb.slew = fresh && haveRef && !overLimit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      haveRef <= 1'b0;
      lastSec <= '0;
      lastNs  <= '0;
    end else if (fresh) begin
      haveRef <= 1'b1;
      lastSec <= refSec;
      lastNs  <= refNs;
    end
  end
endmodule

// File: rtl/pi_time_dp.sv
module pi_time_dp
  import pi_time_pkg::*;
#(
  parameter int SEC_W    = 32,
  parameter int NS_W     = 30,
  parameter int FS_W     = 21,
  parameter int STEP_NS  = 25,
  parameter int KP_W     = 12,
  parameter int KP_FRAC  = 2,
  parameter int CORR_W   = 18,
  parameter int LIMIT_NS = 1000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  tk_strobe_t             stb,
  input  logic [SEC_W-1:0]       refSec,
  input  logic [NS_W-1:0]        refNs,
  input  logic [KP_W-1:0]        kpGain,
  output logic                   overLimit,
  output logic [SEC_W-1:0]       timeSec,
  output logic [NS_W-1:0]        timeNs,
  output logic signed [FS_W-1:0] timeFs
);
  localparam int ERR_W  = $clog2(LIMIT_NS + 1) + 1;
  localparam int DIFF_W = NS_W + 3;
  localparam int PROD_W = KP_W + ERR_W + 1;
  localparam int WIDE   = ((PROD_W > CORR_W + 1) ? PROD_W : CORR_W + 1) + 1;
  localparam logic signed [DIFF_W-1:0] SEC_NS = DIFF_W'(1_000_000_000);
  localparam logic signed [DIFF_W-1:0] LIM_D  = DIFF_W'(LIMIT_NS);
  localparam logic signed [ERR_W-1:0]  LIM_E  = ERR_W'(LIMIT_NS);
  localparam logic signed [WIDE-1:0]   CMAX   = WIDE'((1 << (CORR_W - 1)) - 1);
  localparam logic signed [WIDE-1:0]   CMIN   = -CMAX;
  localparam logic signed [FS_W:0]     FS_ONE = (FS_W + 1)'(1_000_000);
  localparam logic [NS_W:0]            NS_WRAP = (NS_W + 1)'(1_000_000_000);
  localparam logic [NS_W:0]            NS_STEP = (NS_W + 1)'(STEP_NS);

  function automatic logic signed [CORR_W-1:0] clipCorr(input logic signed [WIDE-1:0] v);
    if (v > CMAX)      return CMAX[CORR_W-1:0];
    else if (v < CMIN) return CMIN[CORR_W-1:0];
    else               return v[CORR_W-1:0];
  endfunction

  logic signed [SEC_W:0]    secDiff;
  logic signed [DIFF_W-1:0] nsDiff, errNs;
  logic                     secNear;
  logic signed [ERR_W-1:0]  errSat;
  logic signed [PROD_W-1:0] prod;
  logic signed [WIDE-1:0]   pWide, iWide, cWide;
  logic signed [CORR_W-1:0] pReg, integ, pNext, iNext, corr;
  logic signed [FS_W:0]     fsSum;
  logic signed [FS_W-1:0]   fsNext;
  logic [NS_W:0]            nsInc, nsSum;
  logic [NS_W-1:0]          nsNext;
  logic [SEC_W-1:0]         secNext;

  // error formation: only a one-second window is resolved exactly
  always_comb begin
    secDiff = $signed({1'b0, refSec}) - $signed({1'b0, timeSec});
    nsDiff  = $signed({3'b000, refNs}) - $signed({3'b000, timeNs});
    secNear = 1'b1;
    errNs   = nsDiff;
    if (secDiff == 1)       errNs = nsDiff + SEC_NS;
    else if (secDiff == -1) errNs = nsDiff - SEC_NS;
    else if (secDiff != 0)  secNear = 1'b0;
    overLimit = !secNear || (errNs > LIM_D) || (errNs < -LIM_D);
    if (errNs > LIM_D)       errSat = LIM_E;
    else if (errNs < -LIM_D) errSat = -LIM_E;
    else                     errSat = errNs[ERR_W-1:0];
  end

  // loop filter terms
  always_comb begin
    prod  = $signed({1'b0, kpGain}) * errSat;
    pWide = WIDE'(prod >>> KP_FRAC);
    pNext = clipCorr(pWide);
    if (errSat > 0)      iWide = WIDE'(integ) + WIDE'(1);
    else if (errSat < 0) iWide = WIDE'(integ) - WIDE'(1);
    else                 iWide = WIDE'(integ);
    iNext = clipCorr(iWide);
    cWide = WIDE'(pReg) + WIDE'(integ);
    corr  = clipCorr(cWide);
  end

  // femtosecond remainder and nanosecond/second advance
  always_comb begin
    fsSum = (FS_W + 1)'(timeFs) + (FS_W + 1)'(corr);
    if (fsSum >= FS_ONE) begin
      fsNext = FS_W'(fsSum - FS_ONE);
      nsInc  = NS_STEP + 1'b1;
    end else if (fsSum <= -FS_ONE) begin
      fsNext = FS_W'(fsSum + FS_ONE);
      nsInc  = NS_STEP - 1'b1;
    end else begin
      fsNext = FS_W'(fsSum);
      nsInc  = NS_STEP;
    end
    nsSum = {1'b0, timeNs} + nsInc;
    if (nsSum >= NS_WRAP) begin
      nsNext  = NS_W'(nsSum - NS_WRAP);
      secNext = timeSec + SEC_W'(1);
    end else begin
      nsNext  = nsSum[NS_W-1:0];
      secNext = timeSec;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timeSec <= '0;
      timeNs  <= '0;
      timeFs  <= '0;
      pReg    <= '0;
      integ   <= '0;
    end else if (stb.load) begin
      timeSec <= refSec;
      timeNs  <= refNs;
      timeFs  <= '0;
      pReg    <= '0;
      integ   <= '0;
    end else begin
      timeSec <= secNext;
      timeNs  <= nsNext;
      timeFs  <= fsNext;
      if (stb.slew) begin
        pReg  <= pNext;
        integ <= iNext;
      end
    end
  end
endmodule

// File: rtl/pi_time_keeper.sv
module pi_time_keeper
  import pi_time_pkg::*;
#(
  parameter int SEC_W    = 32,
  parameter int NS_W     = 30,
  parameter int FS_W     = 21,
  parameter int STEP_NS  = 25,
  parameter int KP_W     = 12,
  parameter int KP_FRAC  = 2,
  parameter int CORR_W   = 18,
  parameter int LIMIT_NS = 1000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   refValid,
  input  logic [SEC_W-1:0]       refSec,
  input  logic [NS_W-1:0]        refNs,
  input  logic [KP_W-1:0]        kpGain,
  output logic [SEC_W-1:0]       timeSec,
  output logic [NS_W-1:0]        timeNs,
  output logic signed [FS_W-1:0] timeFs
);
  tk_strobe_t ctlStb;
  logic       overLimit;

  pi_time_ctl #(.SEC_W(SEC_W), .NS_W(NS_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .refValid(refValid), .refSec(refSec),
    .refNs(refNs), .overLimit(overLimit), .stb(ctlStb)
  );

  pi_time_dp #(
    .SEC_W(SEC_W), .NS_W(NS_W), .FS_W(FS_W), .STEP_NS(STEP_NS), .KP_W(KP_W),
    .KP_FRAC(KP_FRAC), .CORR_W(CORR_W), .LIMIT_NS(LIMIT_NS)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(ctlStb), .refSec(refSec), .refNs(refNs),
    .kpGain(kpGain), .overLimit(overLimit), .timeSec(timeSec),
    .timeNs(timeNs), .timeFs(timeFs)
  );
endmodule

// File: rtl/pi_time_keeper_chk.sv
module pi_time_keeper_chk
  import pi_time_pkg::*;
#(
  parameter int SEC_W   = 32,
  parameter int NS_W    = 30,
  parameter int FS_W    = 21,
  parameter int STEP_NS = 25
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   refValid,
  input logic [SEC_W-1:0]       refSec,
  input logic [NS_W-1:0]        refNs,
  input logic [SEC_W-1:0]       timeSec,
  input logic [NS_W-1:0]        timeNs,
  input logic signed [FS_W-1:0] timeFs,
  input tk_strobe_t             stb
);
  logic             prevRun, prevLoad, prevAccept;
  logic [NS_W-1:0]  prevNs;
  logic [SEC_W-1:0] prevSec;
  logic [SEC_W-1:0] prevRefSec;
  logic [NS_W-1:0]  prevRefNs;
  longint           nsStep;
  logic             stepOk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prevRun    <= 1'b0;
      prevLoad   <= 1'b0;
      prevAccept <= 1'b0;
      prevNs     <= '0;
      prevSec    <= '0;
      prevRefSec <= '0;
      prevRefNs  <= '0;
    end else begin
      prevRun    <= 1'b1;
      prevLoad   <= stb.load;
      prevAccept <= stb.load || stb.slew;
      prevNs     <= timeNs;
      prevSec    <= timeSec;
      prevRefSec <= refSec;
      prevRefNs  <= refNs;
    end
  end

  always_comb begin
    nsStep = longint'(timeNs) - longint'(prevNs);
    if (nsStep < 0) nsStep = nsStep + 64'sd1_000_000_000;
    stepOk = (nsStep >= STEP_NS - 1) && (nsStep <= STEP_NS + 1) &&
             ((timeNs < prevNs) ? (timeSec == prevSec + SEC_W'(1)) : (timeSec == prevSec));
  end

  AST_NS_BELOW_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    timeNs < NS_W'(1_000_000_000)); // R2
  AST_STEP_AND_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (prevRun && !prevLoad) |-> stepOk); // R3
  AST_FS_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    (timeFs < FS_W'(1_000_000)) && (timeFs > -FS_W'(1_000_000))); // R3
  AST_LOAD_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    stb.load |=> (timeSec == $past(refSec)) && (timeNs == $past(refNs)) && (timeFs == '0)); // R4
  AST_STROBE_NEEDS_REF: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.load || stb.slew) |-> (refValid && !(stb.load && stb.slew))); // R5
  AST_REPEAT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (prevAccept && refValid && refSec == prevRefSec && refNs == prevRefNs)
      |-> !(stb.load || stb.slew)); // R5
endmodule

bind pi_time_keeper pi_time_keeper_chk #(
  .SEC_W(SEC_W), .NS_W(NS_W), .FS_W(FS_W), .STEP_NS(STEP_NS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .refValid(refValid), .refSec(refSec),
  .refNs(refNs), .timeSec(timeSec), .timeNs(timeNs), .timeFs(timeFs),
  .stb(ctlStb)
);

// File: tb/pi_time_keeper_bench.sv
module pi_time_keeper_bench;
  localparam int CLK_PERIOD = 10;
  localparam longint NS_S = 1000000000;
  localparam longint FS_N = 1000000;
  localparam longint CMAX = 131071;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               refValid = 1'b0;
  logic [31:0]        refSec = '0;
  logic [29:0]        refNs = '0;
  logic [11:0]        kpGain = 12'd10;
  logic [31:0]        timeSec;
  logic [29:0]        timeNs;
  logic signed [20:0] timeFs;

  int checks = 0;
  int fails = 0;
  bit runCmp = 1'b0;
  bit done = 1'b0;
  string tag = "R1";
  int saw24 = 0;
  int saw26 = 0;
  longint lastNsSeen = 0;

  longint mSec = 0, mNs = 0, mFs = 0, mP = 0, mI = 0, mPrevSec = 0, mPrevNs = 0;
  bit mHave = 1'b0;

  pi_time_keeper u_pi_time_keeper (
    .clk(clk), .rst_n(rst_n), .refValid(refValid), .refSec(refSec),
    .refNs(refNs), .kpGain(kpGain), .timeSec(timeSec), .timeNs(timeNs),
    .timeFs(timeFs)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic longint clipL(longint v);
    if (v > CMAX) return CMAX;
    if (v < -CMAX) return -CMAX;
    return v;
  endfunction

  // behavioural reference model, total-nanosecond error
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mSec = 0; mNs = 0; mFs = 0; mP = 0; mI = 0; mHave = 0; mPrevSec = 0; mPrevNs = 0;
    end else begin
      longint corr, e, prod, q, f, ns;
      bit fresh, doLoad, doSlew;
      corr = clipL(mP + mI);
      fresh = refValid && (!mHave || longint'(refSec) != mPrevSec || longint'(refNs) != mPrevNs);
      e = (longint'(refSec) - mSec) * NS_S + longint'(refNs) - mNs;
      doLoad = fresh && (!mHave || e > 1000 || e < -1000);
      doSlew = fresh && !doLoad;
      if (fresh) begin
        mHave = 1; mPrevSec = refSec; mPrevNs = refNs;
      end
      if (doLoad) begin
        mSec = refSec; mNs = refNs; mFs = 0; mP = 0; mI = 0;
      end else begin
        f = mFs + corr;
        ns = mNs + 25;
        if (f >= FS_N) begin f = f - FS_N; ns = ns + 1; end
        else if (f <= -FS_N) begin f = f + FS_N; ns = ns - 1; end
        mFs = f;
        if (ns >= NS_S) begin ns = ns - NS_S; mSec = (mSec + 1) & 64'hFFFF_FFFF; end
        mNs = ns;
        if (doSlew) begin
          prod = longint'(kpGain) * e;
          q = prod / 4;
          if (prod < 0 && (prod % 4) != 0) q = q - 1;
          mP = clipL(q);
          if (e > 0) mI = clipL(mI + 1);
          else if (e < 0) mI = clipL(mI - 1);
        end
      end
    end
  end

  // cycle-by-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (runCmp && rst_n && !done) begin
      longint d;
      checks++;
      if (longint'(timeSec) != mSec || longint'(timeNs) != mNs || longint'(timeFs) != mFs) begin
        fails++;
        $display("FAIL %s: time %0d.%0d fs %0d, expected %0d.%0d fs %0d", tag,
                 timeSec, timeNs, timeFs, mSec, mNs, mFs);
      end
      d = longint'(timeNs) - lastNsSeen;
      if (d == 24) saw24++;
      if (d == 26) saw26++;
      lastNsSeen = timeNs;
    end
  end

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic driveRef(input longint s, input longint n);
    refValid = 1'b1;
    refSec = 32'(s);
    refNs = 30'(n);
  endtask

  // reference offset from the model's present time by d nanoseconds
  task automatic slewBy(input longint d);
    longint tot;
    tot = mSec * NS_S + mNs + d;
    driveRef(tot / NS_S, tot % NS_S);
    cyc(1);
    refValid = 1'b0;
  endtask

  task automatic fsDelta(input string req, input longint exp);
    longint a, b;
    a = timeFs;
    cyc(1);
    b = timeFs;
    if (b - a == exp - FS_N || b - a == exp + FS_N) check(req, exp, exp);
    else check(req, b - a, exp);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog: run did not end, expected completion");
    finishRun();
  end

  initial begin
    longint s0, tSec, tNs, tot;
    #3;
    // R1: outputs cleared under reset
    check("R1", longint'(timeSec) + longint'(timeNs) + longint'(timeFs < 0 ? -timeFs : timeFs), 0);
    cyc(2);
    rst_n = 1'b1;
    runCmp = 1'b1;

    tag = "R2";
    cyc(50);
    s0 = timeNs;
    cyc(4);
    check("R2", timeNs, s0 + 100);

    // R4: first reference loads exactly
    tag = "R4";
    driveRef(5, 999_999_000);
    cyc(1);
    check("R4", timeSec, 5);
    check("R4", timeNs, 999_999_000);
    check("R4", timeFs, 0);
    // R5: held value is ignored
    tag = "R5";
    cyc(5);
    check("R5", timeNs, 999_999_125);
    check("R5", timeFs, 0);
    refValid = 1'b0;
    tag = "R2";
    cyc(60);
    check("R2", timeSec, 6);

    // R7: proportional slew, positive error
    tag = "R7";
    kpGain = 12'd10;
    slewBy(500);
    cyc(1);
    fsDelta("R7", 1251);
    cyc(3000);

    // R3: negative correction produces borrows
    tag = "R3";
    slewBy(-300);
    cyc(1);
    fsDelta("R3", -750);
    cyc(3000);

    // R6: far reference reloads
    tag = "R6";
    tot = mSec * NS_S + mNs + 5000;
    tSec = tot / NS_S; tNs = tot % NS_S;
    driveRef(tSec, tNs);
    cyc(1);
    refValid = 1'b0;
    check("R6", timeSec, tSec);
    check("R6", timeNs, tNs);
    check("R6", timeFs, 0);

    // R8: integrator steps by sign of error
    tag = "R8";
    kpGain = 12'd0;
    for (int i = 0; i < 3; i++) begin slewBy(1); cyc(2); end
    fsDelta("R8", 3);
    for (int i = 0; i < 2; i++) begin slewBy(-1); cyc(2); end
    fsDelta("R8", 1);
    slewBy(0);
    cyc(2);
    fsDelta("R8", 1);

    // R9 / R7: saturation, and carry landing on the second wrap
    tag = "R9";
    kpGain = 12'd4095;
    for (int k = 0; k < 8; k++) begin
      driveRef(20 + k, 999_999_500 - 25 * k);
      cyc(1);
      refValid = 1'b0;
      slewBy(800);
      cyc(1);
      fsDelta("R9", CMAX);
      cyc(40);
    end
    tag = "R7";
    slewBy(1000);
    cyc(1);
    fsDelta("R7", CMAX);

    tag = "R2";
    cyc(100);
    check("R3", saw24 > 0, 1);
    check("R3", saw26 > 0, 1);
    finishRun();
  end
endmodule